// File: doc/BRIEF.md
# Two-Level Page Permission Checker

This block decides whether a single memory access may proceed, based on the protection flags found in the two entries of a two-level page translation. Each request carries the current privilege level, the access direction (read or write), the directory-level entry word and the table-level entry word. A separate write-protect enable input decides whether supervisor writes must honour read-only pages.

Neither level can grant more than the other. The page counts as user-accessible only when both entries mark it so, and as writable only when both entries mark it writable. Privilege collapses to two classes: supervisor and user. The answer is an allow/fault outcome plus a three-bit fault code. It is registered once and returned over a valid/ready handshake, so a table walker can place the checker in its response path and sustain one request per cycle.

Top module: `page_perm_checker`

## Requirements
- R1: While the synchronous active-high reset is asserted and in the first cycle after it is released, `outValid` is low and `inReady` is high.
- R2: Privilege levels 0, 1 and 2 count as supervisor mode. Level 3 counts as user mode.
- R3: Within each entry word, bit 1 is the writable flag (1 = writable, 0 = read-only) and bit 2 is the user flag (1 = user page, 0 = supervisor-only page). The effective flag is the AND of the directory and table bits. All other entry bits have no effect.
- R4: When write-protect is disabled, every supervisor-mode read and write is allowed, whatever the flags.
- R5: A user-mode access to a page whose effective user flag is 0 faults, for reads and for writes.
- R6: A user-mode read of an effective user page is allowed. A user-mode write to such a page is allowed only if the page is effectively writable.
- R7: When write-protect is enabled, a write to an effectively read-only page faults in every mode. Supervisor reads remain allowed.
- R8: An allowed response carries fault code 000. A faulting response carries bit 0 = 1, bit 1 = the access was a write, and bit 2 = the access came from user mode.
- R9: A request is taken when `inValid` and `inReady` are both high. Its response appears in the next cycle with `outValid` high. The response is held unchanged until a cycle with `outReady` high. `inReady` is low exactly when `outValid` is high and `outReady` is low.
- R10: The write-protect input is sampled with the accepted request. Changes to it, or to request inputs, while a response is held do not alter that response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request valid |
| inReady | output | 1 | Request can be taken this cycle |
| inPriv | input | 2 | Current privilege level |
| inWrite | input | 1 | 1 = write access, 0 = read access |
| dirEntry | input | ENTRY_W | Directory-level entry word |
| tblEntry | input | ENTRY_W | Table-level entry word |
| wpEnable | input | 1 | Supervisor write-protect enable |
| outValid | output | 1 | Response valid |
| outReady | input | 1 | Consumer takes the response |
| outAllow | output | 1 | 1 = access allowed |
| outFault | output | 3 | Fault code (see R8) |

## Verification
Two functions can collide in one cycle: draining the held response and loading a new one. This happens when `outReady` rises while a fresh request is waiting, so the old result leaves and the new one is captured at the same edge. The bench provokes this by stalling the output with a faulting response and offering a different, allowed request during the stall. It also toggles write-protect during the stall. It then checks that the held response stayed intact, that `inReady` followed `outReady` in the release cycle, and that the next response is the arithmetic result of the second request.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;
  localparam int RW_BIT  = 1;
  localparam int US_BIT  = 2;
  localparam int PRIV_W  = 2;
  localparam int FAULT_W = 3;
  localparam logic [PRIV_W-1:0] USER_PRIV = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
  } ctrlStrobes_t;

  // fault code layout: {user, write, violation}
  typedef struct packed {
    logic user;
    logic write;
    logic viol;
  } faultCode_t;
endpackage

// File: rtl/perm_datapath.sv
module perm_datapath
  import pgperm_pkg::*;
#(
  parameter int ENTRY_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        strobes,
  input  logic [PRIV_W-1:0]   reqPriv,
  input  logic                reqWrite,
  input  logic [ENTRY_W-1:0]  reqDir,
  input  logic [ENTRY_W-1:0]  reqTbl,
  input  logic                reqWp,
  output logic                resAllow,
  output logic [FAULT_W-1:0]  resFault
);
  logic       userMode;
  logic       effUser;
  logic       effWritable;
  logic       violation;
  faultCode_t nextCode;
  faultCode_t codeQ;
  logic       allowQ;

  always_comb begin
    userMode    = (reqPriv == USER_PRIV);
    effUser     = reqDir[US_BIT] & reqTbl[US_BIT];
    effWritable = reqDir[RW_BIT] & reqTbl[RW_BIT];
    if (userMode) begin
      violation = !effUser || (reqWrite && !effWritable);
    end else begin
      violation = reqWrite && reqWp && !effWritable;
    end
    nextCode = '0;
    if (violation) begin
      nextCode.viol  = 1'b1;
      nextCode.write = reqWrite;
      nextCode.user  = userMode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      allowQ <= 1'b0;
      codeQ  <= '0;
    end else if (strobes.load) begin
      allowQ <= !violation;
      codeQ  <= nextCode;
    end
  end

  assign resAllow = allowQ;
  assign resFault = codeQ;

  AST_SUP_NOWP_ALLOW: assert property (@(posedge clk) disable iff (rst)
    strobes.load && (reqPriv != USER_PRIV) && !reqWp |=> resAllow); // R4
  AST_USER_SUPPAGE_FAULT: assert property (@(posedge clk) disable iff (rst)
    strobes.load && (reqPriv == USER_PRIV) && !(reqDir[US_BIT] && reqTbl[US_BIT])
    |=> !resAllow && resFault[2]); // R5
  AST_WP_RO_WRITE_FAULT: assert property (@(posedge clk) disable iff (rst)
    strobes.load && reqWp && reqWrite && !(reqDir[RW_BIT] && reqTbl[RW_BIT])
    |=> !resAllow && resFault[1]); // R7
  AST_CODE_MATCHES_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> (resAllow == (resFault == '0))); // R8
  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> $stable(resAllow) && $stable(resFault)); // R10
endmodule

// File: rtl/perm_control.sv
module perm_control
  import pgperm_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         outReady,
  output logic         inReady,
  output logic         outValid,
  output ctrlStrobes_t strobes
);
  logic validQ;
  logic accept;

  always_comb begin
    inReady      = !(validQ && !outReady);
    accept       = inValid && inReady;
    strobes.load = accept;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= 1'b0;
    end else if (accept) begin
      validQ <= 1'b1;
    end else if (outReady) begin
      validQ <= 1'b0;
    end
  end

  assign outValid = validQ;

  AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> !outValid); // R1
  AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
    inValid && inReady |=> outValid); // R9
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid); // R9
  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    outValid && outReady && !inValid |=> !outValid); // R9
endmodule

// File: rtl/page_perm_checker.sv
module page_perm_checker
  import pgperm_pkg::*;
#(
  parameter int ENTRY_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  output logic               inReady,
  input  logic [1:0]         inPriv,
  input  logic               inWrite,
  input  logic [ENTRY_W-1:0] dirEntry,
  input  logic [ENTRY_W-1:0] tblEntry,
  input  logic               wpEnable,
  output logic               outValid,
  input  logic               outReady,
  output logic               outAllow,
  output logic [2:0]         outFault
);
  ctrlStrobes_t strobes;

  perm_control i_control (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobes  (strobes)
  );

  perm_datapath #(.ENTRY_W(ENTRY_W)) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .reqPriv  (inPriv),
    .reqWrite (inWrite),
    .reqDir   (dirEntry),
    .reqTbl   (tblEntry),
    .reqWp    (wpEnable),
    .resAllow (outAllow),
    .resFault (outFault)
  );
endmodule

// File: tb/test_page_perm_checker.sv
module test_page_perm_checker;
  localparam int EW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [1:0]    inPriv = '0;
  logic          inWrite = 1'b0;
  logic [EW-1:0] dirEntry = '0;
  logic [EW-1:0] tblEntry = '0;
  logic          wpEnable = 1'b0;
  logic          outValid;
  logic          outReady = 1'b1;
  logic          outAllow;
  logic [2:0]    outFault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  page_perm_checker #(.ENTRY_W(EW)) i_page_perm_checker (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inPriv(inPriv), .inWrite(inWrite), .dirEntry(dirEntry),
    .tblEntry(tblEntry), .wpEnable(wpEnable), .outValid(outValid),
    .outReady(outReady), .outAllow(outAllow), .outFault(outFault)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected result computed from the requirement rules
  function automatic logic [3:0] model(input int priv, input int wr, input int wp,
                                       input int dflags, input int tflags);
    int us, rwb, user, viol;
    us   = ((dflags >> 1) & 1) & ((tflags >> 1) & 1);   // R3
    rwb  = (dflags & 1) & (tflags & 1);                  // R3
    user = (priv == 3) ? 1 : 0;                          // R2
    if (user == 1) viol = (us == 0 || (wr == 1 && rwb == 0)) ? 1 : 0;
    else           viol = (wr == 1 && wp == 1 && rwb == 0) ? 1 : 0;
    if (viol == 1) return {1'b0, user[0], wr[0], 1'b1};
    return 4'b1000;
  endfunction

  function automatic logic [EW-1:0] mkEntry(input int flags, input int filler);
    logic [EW-1:0] e;
    e = (filler == 1) ? {EW{1'b1}} : '0;
    e[1] = flags[0];
    e[2] = flags[1];
    return e;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [3:0] exp;
    string tag;
    repeat (2) @(negedge clk);
    check(outValid == 1'b0, "R1", outValid, 0);
    check(inReady == 1'b1, "R1", inReady, 1);
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R1", outValid, 0);
    check(inReady == 1'b1, "R1", inReady, 1);

    // exhaustive sweep, one request per cycle, back to back
    for (int idx = 0; idx < 512; idx++) begin
      int priv, wr, wp, df, tf, fill;
      priv = idx & 3; wr = (idx >> 2) & 1; wp = (idx >> 3) & 1;
      df = (idx >> 4) & 3; tf = (idx >> 6) & 3; fill = (idx >> 8) & 1;
      inValid  = 1'b1;
      inPriv   = priv[1:0];
      inWrite  = wr[0];
      wpEnable = wp[0];
      dirEntry = mkEntry(df, fill);
      tblEntry = mkEntry(tf, fill ^ (idx & 1));
      exp = model(priv, wr, wp, df, tf);
      @(negedge clk);
      if (priv != 3 && wp == 0)                    tag = "R4";
      else if (priv == 3 && (df & tf & 2) == 0)    tag = "R5";
      else if (priv == 3)                          tag = "R6";
      else                                         tag = "R7";
      check(outValid == 1'b1, "R9", outValid, 1);
      check(outAllow == exp[3], tag, outAllow, exp[3]);
      check(outFault == exp[2:0], "R8", outFault, exp[2:0]);
    end
    inValid = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R9", outValid, 0);

    // stall: user read of supervisor page -> fault 101
    inValid = 1'b1; inPriv = 2'd3; inWrite = 1'b0; wpEnable = 1'b0;
    dirEntry = mkEntry(3, 0); tblEntry = mkEntry(1, 0);
    outReady = 1'b0;
    @(negedge clk);
    check(outValid && !outAllow && outFault == 3'b101, "R5", outFault, 5);
    check(inReady == 1'b0, "R9", inReady, 0);
    // second request offered during stall: supervisor write, ro page, wp toggled
    inPriv = 2'd0; inWrite = 1'b1; dirEntry = mkEntry(1, 1); tblEntry = mkEntry(0, 1);
    for (int k = 0; k < 3; k++) begin
      wpEnable = k[0];
      @(negedge clk);
      check(outValid && !outAllow && outFault == 3'b101, "R10", outFault, 5);
      check(inReady == 1'b0, "R9", inReady, 0);
    end
    wpEnable = 1'b0;
    outReady = 1'b1;
    #1;
    check(inReady == 1'b1, "R9", inReady, 1);
    @(negedge clk);
    check(outValid && outAllow && outFault == 3'b000, "R4", outFault, 0);
    // same request with wp set now faults with code 011
    wpEnable = 1'b1;
    @(negedge clk);
    check(outValid && !outAllow && outFault == 3'b011, "R7", outFault, 3);
    // supervisor read of ro page with wp set stays allowed
    inWrite = 1'b0;
    @(negedge clk);
    check(outValid && outAllow && outFault == 3'b000, "R7", outFault, 0);
    inValid = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R9", outValid, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule